// File: doc/BRIEF.md
# Two-Stage Storage-Card Clock Divider

This block makes the clock enables for a storage-card host from one fast source clock. A pre-divider stage divides the source by 1, 2, 4, 8 or 16 and makes a high-speed intermediate clock. A final stage divides that intermediate clock by 2 or 4 and makes the card clock. The total division is the product of the two stages, from 2 up to 64. One control register holds both divide fields and two stop bits, one for each clock. The block outputs single-cycle enables for both clocks, a card clock level with a duty cycle of one half, and an "enabled" status.

Software can write the control register directly. It can also use two command pulses. The stop command sets both stop bits. The start command clears the card stop bit and sets the intermediate stop bit from the current pre-divide field: that stop bit is set whenever the pre-divide code is 2 or more. A new divide setting is held back until the current card-clock period ends, so that no short pulse is produced. A write with a reserved code is dropped.

Top module: `sd_clkdiv`

## Requirements
- R1: Control register layout: bit 9 = intermediate stop, bit 8 = card stop, bits 4:2 = pre-divide code, bits 1:0 = final code. A valid write stores these fields. Bits 7:5 and 15:10 are not stored and always read as 0 on `ctrl_q`.
- R2: A write whose pre-divide code is 5, 6 or 7, or whose final code is 2 or 3, is ignored. The register and the output timing stay as before.
- R3: When the intermediate stop bit is 0, `hs_ce` pulses once every 2^p source cycles, where p is the active pre-divide code. Every `card_ce` pulse falls on an `hs_ce` pulse.
- R4: When the card stop bit is 0, `card_ce` pulses once every N = 2^p * 2^(f+1) source cycles, where f is the active final code (0 gives /2, 1 gives /4). In each period, `card_clk` is high for N/2 cycles.
- R5: A new divide setting takes effect only after the card-clock period in progress has ended. That period keeps its old length.
- R6: While the card stop bit is 1, `card_ce` and `card_clk` stay at 0.
- R7: While the intermediate stop bit is 1, `hs_ce` stays at 0. The card clock keeps running if its own stop bit is 0.
- R8: `clk_on` is 1 exactly when both stop bits are 0.
- R9: A `stop_req` pulse sets both stop bits and leaves the divide fields unchanged.
- R10: A `start_req` pulse clears the card stop bit. It sets the intermediate stop bit to 1 if the pre-divide code is 2 or more, and to 0 otherwise.
- R11: Reset loads 0x301: both clocks stopped, pre-divide code 0, final code 1. When events arrive in the same cycle, the order of precedence is `stop_req`, then `start_req`, then `wr_en`. The lower-priority events are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| stop_req | input | 1 | Stop-both-clocks command pulse |
| start_req | input | 1 | Re-enable command pulse |
| ctrl_q | output | 16 | Current control register contents |
| clk_on | output | 1 | Both clocks running |
| hs_ce | output | 1 | Intermediate clock enable, one cycle wide |
| card_ce | output | 1 | Card clock enable, one cycle wide at period end |
| card_clk | output | 1 | Card clock level, low half then high half |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any command or write. They also assume that reserved codes reach the register only through `wr_data`, never through reset. The stimulus asserts `stop_req`, `start_req` and `wr_en` together only in the precedence tests, and drives every input at the falling edge. Settings that must start on a period boundary are written one cycle after a `card_ce` pulse has been seen. This places the change strictly inside a period and gives the old period a known length.

// File: rtl/sd_clkdiv_pkg.sv
package sd_clkdiv_pkg;
   localparam int CTRL_W      = 16;
   localparam int HS_STOP_BIT = 9;
   localparam int CK_STOP_BIT = 8;
   localparam int PRE_LSB     = 2;
   localparam int PRE_W       = 3;
   localparam int FIN_LSB     = 0;
   localparam int FIN_W       = 2;

   typedef struct packed {
      logic             hs_stop;
      logic             ck_stop;
      logic [PRE_W-1:0] pre;
      logic [FIN_W-1:0] fin;
   } ctrl_t;

   function automatic logic [CTRL_W-1:0] ctrl_pack(ctrl_t c);
      logic [CTRL_W-1:0] v;
      v = '0;
      v[HS_STOP_BIT]           = c.hs_stop;
      v[CK_STOP_BIT]           = c.ck_stop;
      v[PRE_LSB +: PRE_W]      = c.pre;
      v[FIN_LSB +: FIN_W]      = c.fin;
      return v;
   endfunction
endpackage

// File: rtl/sd_clkdiv_ctrl.sv
module sd_clkdiv_ctrl
   import sd_clkdiv_pkg::*;
#(
   parameter int PRE_MAX      = 4,
   parameter int FIN_MAX      = 1,
   parameter int HS_STOP_FROM = 2,
   parameter int RST_PRE      = 0,
   parameter int RST_FIN      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              stop_req,
   input  logic              start_req,
   output ctrl_t             cfg,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam logic [PRE_W-1:0] PRE_LIM  = PRE_W'(PRE_MAX);
   localparam logic [FIN_W-1:0] FIN_LIM  = FIN_W'(FIN_MAX);
   localparam logic [PRE_W-1:0] HS_FROM  = PRE_W'(HS_STOP_FROM);

   logic [PRE_W-1:0] wr_pre;
   logic [FIN_W-1:0] wr_fin;
   logic             wr_ok;

   assign wr_pre = wr_data[PRE_LSB +: PRE_W];
   assign wr_fin = wr_data[FIN_LSB +: FIN_W];
   assign wr_ok  = (wr_pre <= PRE_LIM) && (wr_fin <= FIN_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.hs_stop <= 1'b1;
         cfg.ck_stop <= 1'b1;
         cfg.pre     <= PRE_W'(RST_PRE);
         cfg.fin     <= FIN_W'(RST_FIN);
      end else if (stop_req) begin
         cfg.hs_stop <= 1'b1;
         cfg.ck_stop <= 1'b1;
      end else if (start_req) begin
         cfg.hs_stop <= (cfg.pre >= HS_FROM);
         cfg.ck_stop <= 1'b0;
      end else if (wr_en && wr_ok) begin
         cfg.hs_stop <= wr_data[HS_STOP_BIT];
         cfg.ck_stop <= wr_data[CK_STOP_BIT];
         cfg.pre     <= wr_pre;
         cfg.fin     <= wr_fin;
      end
   end

   assign ctrl_q = ctrl_pack(cfg);
endmodule

// File: rtl/sd_clkdiv_prestage.sv
module sd_clkdiv_prestage #(
   parameter int PRE_W   = 3,
   parameter int PRE_MAX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] code,
   output logic             tick
);
   localparam int CNT_W = (PRE_MAX > 0) ? PRE_MAX : 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   // terminal count 2^code - 1: bit i set for every i below code
   for (genvar i = 0; i < CNT_W; i++) begin : g_lim
      assign lim[i] = (code > PRE_W'(i));
   end

   assign tick = (cnt == lim);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sd_clkdiv_finstage.sv
module sd_clkdiv_finstage #(
   parameter int FIN_W      = 2,
   parameter int FIN_MAX    = 1,
   parameter bit HIGH_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [FIN_W-1:0] code,
   output logic             period_end,
   output logic             phase_hi
);
   localparam int CNT_W = FIN_MAX + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] half_mask;
   logic             upper;

   // terminal count 2^(code+1) - 1; the upper half is flagged by bit 'code'
   for (genvar i = 0; i < CNT_W; i++) begin : g_lim
      assign lim[i]       = (code >= FIN_W'(i));
      assign half_mask[i] = (code == FIN_W'(i));
   end

   assign period_end = tick && (cnt == lim);
   assign upper      = |(cnt & half_mask);

   if (HIGH_FIRST) begin : g_hi_first
      assign phase_hi = ~upper;
   end else begin : g_lo_first
      assign phase_hi = upper;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (period_end) cnt <= '0;
      else if (tick)       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sd_clkdiv.sv
module sd_clkdiv
   import sd_clkdiv_pkg::*;
#(
   parameter int PRE_MAX      = 4,
   parameter int FIN_MAX      = 1,
   parameter int HS_STOP_FROM = 2,
   parameter int RST_PRE      = 0,
   parameter int RST_FIN      = 1,
   parameter bit HIGH_FIRST   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              stop_req,
   input  logic              start_req,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              clk_on,
   output logic              hs_ce,
   output logic              card_ce,
   output logic              card_clk
);
   if (PRE_MAX >= (1 << PRE_W)) begin : g_bad_pre
      $error("PRE_MAX does not fit the pre-divide field");
   end
   if (FIN_MAX >= (1 << FIN_W)) begin : g_bad_fin
      $error("FIN_MAX does not fit the final-stage field");
   end
   if (RST_PRE > PRE_MAX || RST_FIN > FIN_MAX) begin : g_bad_rst
      $error("reset divide codes must be valid codes");
   end

   ctrl_t            cfg;
   logic [PRE_W-1:0] act_pre;
   logic [FIN_W-1:0] act_fin;
   logic             pre_tick;
   logic             period_end;
   logic             phase_hi;

   sd_clkdiv_ctrl #(
      .PRE_MAX      (PRE_MAX),
      .FIN_MAX      (FIN_MAX),
      .HS_STOP_FROM (HS_STOP_FROM),
      .RST_PRE      (RST_PRE),
      .RST_FIN      (RST_FIN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .stop_req  (stop_req),
      .start_req (start_req),
      .cfg       (cfg),
      .ctrl_q    (ctrl_q)
   );

   // active divide codes follow the register only at a period boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_pre <= PRE_W'(RST_PRE);
         act_fin <= FIN_W'(RST_FIN);
      end else if (period_end) begin
         act_pre <= cfg.pre;
         act_fin <= cfg.fin;
      end
   end

   sd_clkdiv_prestage #(
      .PRE_W   (PRE_W),
      .PRE_MAX (PRE_MAX)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (act_pre),
      .tick  (pre_tick)
   );

   sd_clkdiv_finstage #(
      .FIN_W      (FIN_W),
      .FIN_MAX    (FIN_MAX),
      .HIGH_FIRST (HIGH_FIRST)
   ) u_fin (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (pre_tick),
      .code       (act_fin),
      .period_end (period_end),
      .phase_hi   (phase_hi)
   );

   assign hs_ce    = pre_tick   & ~cfg.hs_stop;
   assign card_ce  = period_end & ~cfg.ck_stop;
   assign card_clk = phase_hi   & ~cfg.ck_stop;
   assign clk_on   = ~cfg.hs_stop & ~cfg.ck_stop;
endmodule

// File: rtl/sd_clkdiv_chk.sv
module sd_clkdiv_chk
   import sd_clkdiv_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [CTRL_W-1:0] wr_data,
   input logic              stop_req,
   input logic              start_req,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic              clk_on,
   input logic              hs_ce,
   input logic              card_ce,
   input logic              card_clk
);
   p_card_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CK_STOP_BIT] |-> (!card_ce && !card_clk));

   p_hs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[HS_STOP_BIT] |-> !hs_ce);

   p_reserved_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stop_req && !start_req &&
       ((wr_data[PRE_LSB +: PRE_W] > 3'd4) || (wr_data[FIN_LSB +: FIN_W] > 2'd1)))
      |=> $stable(ctrl_q));

   p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (ctrl_q[HS_STOP_BIT] && ctrl_q[CK_STOP_BIT] && !clk_on));

   p_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !stop_req) |=>
      (!ctrl_q[CK_STOP_BIT] &&
       (ctrl_q[HS_STOP_BIT] == (ctrl_q[PRE_LSB +: PRE_W] >= 3'd2))));

   p_ce_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (card_ce && !ctrl_q[HS_STOP_BIT]) |-> hs_ce);
endmodule

bind sd_clkdiv sd_clkdiv_chk u_chk (.*);

// File: tb/sd_clkdiv_bench.sv
module sd_clkdiv_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        stop_req = 1'b0;
   logic        start_req = 1'b0;
   logic [15:0] ctrl_q;
   logic        clk_on, hs_ce, card_ce, card_clk;

   typedef struct {
      int per;
      int hs;
      int hi;
   } item_t;

   item_t expq[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    resync = 1'b1;
   bit    have_base = 1'b0;
   int    cyc = 0;
   int    last_ce = 0;
   int    hs_n = 0;
   int    hi_n = 0;
   bit    done = 1'b0;

   always #10 clk = ~clk;

   sd_clkdiv u_sd_clkdiv (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .stop_req  (stop_req),
      .start_req (start_req),
      .ctrl_q    (ctrl_q),
      .clk_on    (clk_on),
      .hs_ce     (hs_ce),
      .card_ce   (card_ce),
      .card_clk  (card_clk)
   );

   // expected period: N = 2^p * 2^(f+1), hs pulses per period, high cycles N/2
   function automatic item_t mk(int p, int f, bit hs_stop);
      item_t it;
      it.per = (1 << p) * (2 << f);
      it.hs  = hs_stop ? 0 : (2 << f);
      it.hi  = it.per / 2;
      return it;
   endfunction

   // monitor: measures each card period and compares with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         cyc = cyc + 1;
         if (card_clk) hi_n = hi_n + 1;
         if (hs_ce)    hs_n = hs_n + 1;
         if (card_ce) begin
            if (resync) begin
               resync    = 1'b0;
               have_base = 1'b1;
            end else if (have_base && expq.size() > 0) begin
               item_t it;
               it = expq.pop_front();
               n_chk = n_chk + 1;
               if ((cyc - last_ce) != it.per || hs_n != it.hs || hi_n != it.hi) begin
                  n_bad = n_bad + 1;
                  $display("FAIL R3/R4/R5 period: period=%0d hs=%0d high=%0d expected period=%0d hs=%0d high=%0d",
                           cyc - last_ce, hs_n, hi_n, it.per, it.hs, it.hi);
               end
            end
            last_ce = cyc;
            hs_n    = 0;
            hi_n    = 0;
         end
      end
   end

   task automatic check(input int act, input int exp, input string tag);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
   endtask

   task automatic wait_empty();
      while (expq.size() != 0) @(negedge clk);
   endtask

   task automatic run_fresh(input logic [15:0] d, input item_t it, input int n);
      wr(d);
      resync = 1'b1;
      for (int i = 0; i < n; i++) expq.push_back(it);
      wait_empty();
   endtask

   // R5: write one cycle after a card pulse; the period in progress keeps its length
   task automatic run_chain(input logic [15:0] d, input item_t old_it, input item_t nw, input int n);
      do @(negedge clk); while (!card_ce);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      expq.push_back(old_it);
      for (int i = 0; i < n; i++) expq.push_back(nw);
      @(negedge clk);
      wr_en = 1'b0;
      wait_empty();
   endtask

   task automatic quiet(input int n, input string tag);
      int c_ce = 0, c_clk = 0, c_hs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (card_ce)  c_ce++;
         if (card_clk) c_clk++;
         if (hs_ce)    c_hs++;
      end
      check(c_ce,  0, {tag, " card_ce pulses"});
      check(c_clk, 0, {tag, " card_clk high cycles"});
      check(c_hs,  0, {tag, " hs_ce pulses"});
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset value, R8 status, R6/R7 stopped outputs
      check(ctrl_q, 16'h0301, "R11 reset register");
      check(clk_on, 0, "R8 status after reset");
      quiet(20, "R6 R7 after reset");

      // R1 R3 R4: divide by 2
      run_fresh(16'h0000, mk(0, 0, 0), 4);
      check(ctrl_q, 16'h0000, "R1 readback /2");
      check(clk_on, 1, "R8 status running");

      // R1 unused bits dropped; R5 boundary change /2 -> /4
      run_chain(16'h00E1, mk(0, 0, 0), mk(0, 1, 0), 3);
      check(ctrl_q, 16'h0001, "R1 unused bits read zero");

      // R5: /4 -> /8 with pre-divide 2
      run_chain(16'h0005, mk(0, 1, 0), mk(1, 1, 0), 3);
      check(ctrl_q, 16'h0005, "R1 readback /8");

      // R7: intermediate stopped, card clock runs (pre 4, final /2)
      run_fresh(16'h0208, mk(2, 0, 1), 3);
      check(ctrl_q, 16'h0208, "R1 readback hs stopped");
      check(clk_on, 0, "R8 status hs stopped");

      // R5 R4: largest total /64
      run_chain(16'h0211, mk(2, 0, 1), mk(4, 1, 1), 2);

      // R2 reserved codes ignored
      wr(16'h0215);
      check(ctrl_q, 16'h0211, "R2 pre code 5 ignored");
      wr(16'h001C);
      check(ctrl_q, 16'h0211, "R2 pre code 7 ignored");
      wr(16'h0012);
      check(ctrl_q, 16'h0211, "R2 final code 2 ignored");
      run_fresh(16'h0217, mk(4, 1, 1), 1);
      check(ctrl_q, 16'h0211, "R2 final code 3 ignored");

      // R9 disable; R6 outputs quiet
      pulse_stop();
      check(ctrl_q, 16'h0311, "R9 stop sets both bits");
      check(clk_on, 0, "R9 status after stop");
      resync = 1'b1;
      quiet(140, "R6 after stop");

      // R10 enable restores table stops
      pulse_start();
      check(ctrl_q, 16'h0211, "R10 start with pre 4");
      check(clk_on, 0, "R8 status hs still stopped");
      wr(16'h000D);
      pulse_stop();
      pulse_start();
      check(ctrl_q, 16'h020D, "R10 start with pre 3");
      wr(16'h0004);
      pulse_stop();
      check(ctrl_q, 16'h0304, "R9 stop keeps fields");
      pulse_start();
      check(ctrl_q, 16'h0004, "R10 start with pre 1");
      check(clk_on, 1, "R8 status after start");
      resync = 1'b1;
      expq.push_back(mk(1, 0, 0));
      expq.push_back(mk(1, 0, 0));
      wait_empty();

      // R11 precedence of simultaneous events
      @(negedge clk);
      stop_req = 1'b1; wr_en = 1'b1; wr_data = 16'h0000;
      @(negedge clk);
      stop_req = 1'b0; wr_en = 1'b0;
      check(ctrl_q, 16'h0304, "R11 stop beats write");
      @(negedge clk);
      start_req = 1'b1; wr_en = 1'b1; wr_data = 16'h0011;
      @(negedge clk);
      start_req = 1'b0; wr_en = 1'b0;
      check(ctrl_q, 16'h0004, "R11 start beats write");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule